// File: doc/BRIEF.md
# Linear CCD line-read timing generator

This block derives, from one system clock, every digital drive signal a three-colour linear CCD needs to read out one line. The signals are the transfer-gate pulse, two complementary shift phases, a last-stage shift clock, the reset-gate clock and the clamp clock. The sensor presents odd and even pixels on two outputs in phase, so every shift-clock period (a "slot") carries one pixel pair. A full line is 7438 pixels, or 3719 slots. The block tags each slot with its region: leading dummy, optical black, invalid or valid.

A line starts from a one-cycle trigger. The block first waits a guard time with the shift clocks parked. It then raises the transfer gate for a programmed number of clocks and waits the guard time again. After that it runs the 3719 slots. The transfer-gate width, the guard time, the reset-pulse width and the clamp-pulse width are inputs counted in system clocks, and the block captures them when it accepts the trigger.

Two clamp modes are available. Per-pixel clamping pulses the reset and clamp clocks in every slot, including during the transfer-gate interval. Line clamping holds the reset clock high around the transfer gate and drives the clamp clock as the inverse of the transfer gate. Every output is a register.

Top module: `ccd_line_timing`

## Requirements
- R1: A line holds exactly 3719 slots of PIX_CYC clocks each (default 4). In a slot, `ph1_o` is low for the first PIX_CYC/2 clocks and high for the rest. `ph2_o` is always the inverse of `ph1_o`, and `ph1_last_o` always equals `ph1_o`. `ph1_o` is high whenever no slots are running. `pix_stb_o` is high for one clock at the start of each slot, in the same cycle as the falling edge of `ph1_o`.
- R2: In the `pix_stb_o` cycle of each slot, `region_o` gives that slot's tag. The encoding is 0 dummy, 1 optical black, 2 invalid, 3 valid. In slot order the regions run: 15 dummy, 48 black, 3 invalid, 3650 valid, 3 invalid. `region_o` changes only in a strobe cycle while busy.
- R3: `tg_o` is high for exactly `tg_width_i` consecutive clocks. A width of 0 acts as 1.
- R4: `busy_o` rises one clock after the trigger is accepted. `tg_o` then stays low for `guard_i` clocks before it rises. After `tg_o` falls, `guard_i` clocks pass before the first `ph1_o` fall. A guard of 0 acts as 1. `ph1_o` stays high and unchanged while `tg_o` is high.
- R5: Per-pixel clamping (`line_clamp_i`=0) uses a phase count that restarts at 0 at every sequence step (guard, gate, guard, shifting) and wraps every PIX_CYC clocks. `rs_o` is high while the count is below the reset width. `cp_o` is high while the count is at least the reset width and below the reset width plus the clamp width. This pulsing continues while `tg_o` is high.
- R6: Line clamping (`line_clamp_i`=1) holds `rs_o` high from the first busy clock until shifting begins. During shifting, `rs_o` pulses per slot as in R5. `cp_o` always equals the inverse of `tg_o`.
- R7: `busy_o` stays high for 2·max(guard,1) + max(tg_width,1) + 3719·PIX_CYC clocks. `done_o` pulses once per line, on the last busy clock.
- R8: A trigger that arrives while busy is ignored, and no line is queued behind it. Changes to the width inputs or the mode input during a line have no effect until the next accepted trigger.
- R9: During reset the outputs are: `tg_o`=0, `ph1_o`=1, `ph2_o`=0, `ph1_last_o`=1, `rs_o`=0, `cp_o`=0, `pix_stb_o`=0, `region_o`=0, `busy_o`=0 and `done_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Line-start trigger |
| line_clamp_i | input | 1 | 1 selects line clamping, 0 selects per-pixel clamping |
| tg_width_i | input | 16 | Transfer-gate width in clocks |
| guard_i | input | 16 | Gap between the transfer gate and shift activity, in clocks |
| rs_width_i | input | 8 | Reset-pulse width in clocks |
| clamp_width_i | input | 8 | Clamp-pulse width in clocks |
| tg_o | output | 1 | Transfer-gate pulse |
| ph1_o | output | 1 | Shift phase 1 |
| ph2_o | output | 1 | Shift phase 2 |
| ph1_last_o | output | 1 | Last-stage shift clock |
| rs_o | output | 1 | Reset-gate clock |
| cp_o | output | 1 | Clamp clock |
| pix_stb_o | output | 1 | Slot-start strobe |
| region_o | output | 2 | Region tag of the current slot |
| busy_o | output | 1 | Line in progress |
| done_o | output | 1 | Last clock of the line |

## Verification
The assertions check four things on every clock. The shift phases stay parked while the gate is open. Each `ph1_o` fall coincides with a strobe, and the region tag moves only on strobes. The reset clock is held high under line clamping, and `done_o` marks the final busy clock. The sequencer also keeps its busy state until the line ends. Only the bench scenarios can show the exact counts: gate and guard widths, total line length, the full 3719-slot region order, and the reset and clamp duty under each mode. They also show that a mid-line trigger and mid-line width changes leave the line untouched.

// File: rtl/ccd_tg_pkg.sv
package ccd_tg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PRE   = 3'd1,
    ST_TG    = 3'd2,
    ST_POST  = 3'd3,
    ST_SHIFT = 3'd4
  } seq_state_e;

  typedef enum logic [1:0] {
    RG_DUMMY   = 2'd0,
    RG_BLACK   = 2'd1,
    RG_INVALID = 2'd2,
    RG_VALID   = 2'd3
  } region_e;
endpackage

// File: rtl/ccd_tg_seq.sv
module ccd_tg_seq
  import ccd_tg_pkg::*;
#(
  parameter int unsigned PIX_CYC = 4,
  parameter int unsigned N_SLOTS = 3719,
  parameter int unsigned WW      = 16,
  parameter int unsigned CW      = 8,
  parameter int unsigned PCW     = 2,
  parameter int unsigned SW      = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          mode_i,
  input  logic [WW-1:0] tg_width_i,
  input  logic [WW-1:0] guard_i,
  input  logic [CW-1:0] rs_width_i,
  input  logic [CW-1:0] cp_width_i,
  output seq_state_e    state_o,
  output logic [PCW-1:0] ph_o,
  output logic [SW-1:0] slot_o,
  output logic          line_end_o,
  output logic          mode_o,
  output logic [CW-1:0] rsw_o,
  output logic [CW-1:0] cpw_o
);
  seq_state_e     state_q, state_d;
  logic [WW-1:0]  dur_q, lim;
  logic [PCW-1:0] ph_q;
  logic [SW-1:0]  slot_q;
  logic [WW-1:0]  tgw_q, grd_q;
  logic           mode_q;
  logic [CW-1:0]  rsw_q, cpw_q;
  logic           dur_end, ph_end, slot_end, line_end;

  assign lim      = (state_q == ST_TG) ? tgw_q : grd_q;
  // zero width behaves as one clock
  assign dur_end  = ({1'b0, dur_q} + (WW+1)'(1)) >= {1'b0, lim};
  assign ph_end   = ph_q == PCW'(PIX_CYC - 1);
  assign slot_end = slot_q == SW'(N_SLOTS - 1);
  assign line_end = (state_q == ST_SHIFT) && ph_end && slot_end;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i)  state_d = ST_PRE;
      ST_PRE:   if (dur_end)  state_d = ST_TG;
      ST_TG:    if (dur_end)  state_d = ST_POST;
      ST_POST:  if (dur_end)  state_d = ST_SHIFT;
      ST_SHIFT: if (line_end) state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      dur_q   <= '0;
      ph_q    <= '0;
      slot_q  <= '0;
      tgw_q   <= '0;
      grd_q   <= '0;
      mode_q  <= 1'b0;
      rsw_q   <= '0;
      cpw_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_d != state_q) begin
        dur_q <= '0;
        ph_q  <= '0;
      end else begin
        dur_q <= dur_q + WW'(1);
        ph_q  <= ph_end ? '0 : ph_q + PCW'(1);
      end
      if (state_q == ST_POST) slot_q <= '0;
      else if (state_q == ST_SHIFT && ph_end) slot_q <= slot_end ? '0 : slot_q + SW'(1);
      // settings track the inputs only while idle
      if (state_q == ST_IDLE) begin
        tgw_q  <= tg_width_i;
        grd_q  <= guard_i;
        mode_q <= mode_i;
        rsw_q  <= rs_width_i;
        cpw_q  <= cp_width_i;
      end
    end
  end

  assign state_o    = state_q;
  assign ph_o       = ph_q;
  assign slot_o     = slot_q;
  assign line_end_o = line_end;
  assign mode_o     = mode_q;
  assign rsw_o      = rsw_q;
  assign cpw_o      = cpw_q;

  a_r8_hold_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && !line_end) |=> (state_q != ST_IDLE));
  a_r1_slot_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SHIFT && !ph_end) |=> $stable(slot_q));
endmodule

// File: rtl/ccd_tg_region.sv
module ccd_tg_region
  import ccd_tg_pkg::*;
#(
  parameter int unsigned SW         = 12,
  parameter int unsigned S_DUMMY    = 15,
  parameter int unsigned S_BLACK    = 48,
  parameter int unsigned S_GAP_LEAD = 3,
  parameter int unsigned S_ACTIVE   = 3650
) (
  input  logic [SW-1:0] slot_i,
  output region_e       region_o
);
  localparam int unsigned NB = 4;
  localparam int unsigned LEN [NB] = '{S_DUMMY, S_BLACK, S_GAP_LEAD, S_ACTIVE};
  localparam region_e     TAG [NB] = '{RG_DUMMY, RG_BLACK, RG_INVALID, RG_VALID};

  logic [31:0] slot_w;
  logic [NB-1:0] below;
  assign slot_w = 32'(slot_i);

  for (genvar g = 0; g < NB; g++) begin : g_bound
    localparam int unsigned EDGE = LEN[0] + ((g >= 1) ? LEN[1] : 0)
                                 + ((g >= 2) ? LEN[2] : 0) + ((g >= 3) ? LEN[3] : 0);
    assign below[g] = slot_w < EDGE;
  end

  always_comb begin
    region_o = RG_INVALID; // trailing gap
    for (int i = NB - 1; i >= 0; i--) begin
      if (below[i]) region_o = TAG[i];
    end
  end
endmodule

// File: rtl/ccd_tg_drv.sv
module ccd_tg_drv
  import ccd_tg_pkg::*;
#(
  parameter int unsigned PIX_CYC = 4,
  parameter int unsigned PCW     = 2,
  parameter int unsigned CW      = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  seq_state_e     state_i,
  input  logic [PCW-1:0] ph_i,
  input  logic           line_end_i,
  input  logic           mode_i,
  input  logic [CW-1:0]  rsw_i,
  input  logic [CW-1:0]  cpw_i,
  input  region_e       region_i,
  output logic           tg_o,
  output logic           ph1_o,
  output logic           ph2_o,
  output logic           ph1_last_o,
  output logic           rs_o,
  output logic           cp_o,
  output logic           stb_o,
  output logic [1:0]     region_o,
  output logic           busy_o,
  output logic           done_o
);
  localparam int unsigned HALF = PIX_CYC / 2;
  localparam int unsigned XW   = (PCW > CW) ? PCW + 1 : CW + 1;

  logic          shifting, near_tg;
  logic [XW-1:0] ph_w, rs_w, cp_end;
  logic          rs_pulse, cp_pulse, ph1_d, rs_d, cp_d;

  assign shifting = state_i == ST_SHIFT;
  assign near_tg  = state_i inside {ST_PRE, ST_TG, ST_POST};
  assign ph_w     = XW'(ph_i);
  assign rs_w     = XW'(rsw_i);
  assign cp_end   = XW'(rsw_i) + XW'(cpw_i);
  assign rs_pulse = ph_w < rs_w;
  assign cp_pulse = (ph_w >= rs_w) && (ph_w < cp_end);
  assign ph1_d    = shifting ? (ph_i >= PCW'(HALF)) : 1'b1;
  assign rs_d     = (mode_i && near_tg) ? 1'b1 : rs_pulse;
  assign cp_d     = mode_i ? (state_i != ST_TG) : cp_pulse;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tg_o       <= 1'b0;
      ph1_o      <= 1'b1;
      ph2_o      <= 1'b0;
      ph1_last_o <= 1'b1;
      rs_o       <= 1'b0;
      cp_o       <= 1'b0;
      stb_o      <= 1'b0;
      region_o   <= RG_DUMMY;
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      tg_o       <= state_i == ST_TG;
      ph1_o      <= ph1_d;
      ph2_o      <= ~ph1_d;
      ph1_last_o <= ph1_d;
      rs_o       <= rs_d;
      cp_o       <= cp_d;
      stb_o      <= shifting && (ph_i == '0);
      region_o   <= shifting ? region_i : RG_DUMMY;
      busy_o     <= state_i != ST_IDLE;
      done_o     <= line_end_i;
    end
  end

  a_r4_quiet_in_tg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tg_o |-> (ph1_o && $stable(ph1_o)));
  a_r1_fall_on_stb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ph1_o) |-> stb_o);
  a_r2_region_on_stb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !$stable(region_o)) |-> stb_o);
  a_r6_rs_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && tg_o) |-> rs_o);
  a_r7_done_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
  a_r7_done_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
endmodule

// File: rtl/ccd_line_timing.sv
module ccd_line_timing
  import ccd_tg_pkg::*;
#(
  parameter int unsigned PIX_CYC    = 4,
  parameter int unsigned DUMMY_PIX  = 30,
  parameter int unsigned BLACK_PIX  = 96,
  parameter int unsigned GAP_PIX    = 6,
  parameter int unsigned ACTIVE_PIX = 7300,
  parameter int unsigned TAIL_PIX   = 6,
  parameter int unsigned WW         = 16,
  parameter int unsigned CW         = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          line_clamp_i,
  input  logic [WW-1:0] tg_width_i,
  input  logic [WW-1:0] guard_i,
  input  logic [CW-1:0] rs_width_i,
  input  logic [CW-1:0] clamp_width_i,
  output logic          tg_o,
  output logic          ph1_o,
  output logic          ph2_o,
  output logic          ph1_last_o,
  output logic          rs_o,
  output logic          cp_o,
  output logic          pix_stb_o,
  output logic [1:0]    region_o,
  output logic          busy_o,
  output logic          done_o
);
  // odd/even outputs shift together: one slot per pixel pair
  localparam int unsigned S_DUMMY  = DUMMY_PIX / 2;
  localparam int unsigned S_BLACK  = BLACK_PIX / 2;
  localparam int unsigned S_GAP    = GAP_PIX / 2;
  localparam int unsigned S_ACTIVE = ACTIVE_PIX / 2;
  localparam int unsigned S_TAIL   = TAIL_PIX / 2;
  localparam int unsigned N_SLOTS  = S_DUMMY + S_BLACK + S_GAP + S_ACTIVE + S_TAIL;
  localparam int unsigned PCW      = (PIX_CYC > 2) ? $clog2(PIX_CYC) : 1;
  localparam int unsigned SW       = $clog2(N_SLOTS);

  seq_state_e     state;
  logic [PCW-1:0] ph;
  logic [SW-1:0]  slot;
  logic           line_end, mode;
  logic [CW-1:0]  rsw, cpw;
  region_e        region;

  ccd_tg_seq #(
    .PIX_CYC(PIX_CYC), .N_SLOTS(N_SLOTS), .WW(WW), .CW(CW), .PCW(PCW), .SW(SW)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_i(line_clamp_i),
    .tg_width_i(tg_width_i), .guard_i(guard_i), .rs_width_i(rs_width_i),
    .cp_width_i(clamp_width_i), .state_o(state), .ph_o(ph), .slot_o(slot),
    .line_end_o(line_end), .mode_o(mode), .rsw_o(rsw), .cpw_o(cpw)
  );

  ccd_tg_region #(
    .SW(SW), .S_DUMMY(S_DUMMY), .S_BLACK(S_BLACK), .S_GAP_LEAD(S_GAP), .S_ACTIVE(S_ACTIVE)
  ) u_region (
    .slot_i(slot), .region_o(region)
  );

  ccd_tg_drv #(
    .PIX_CYC(PIX_CYC), .PCW(PCW), .CW(CW)
  ) u_drv (
    .clk_i(clk_i), .rst_ni(rst_ni), .state_i(state), .ph_i(ph), .line_end_i(line_end),
    .mode_i(mode), .rsw_i(rsw), .cpw_i(cpw), .region_i(region),
    .tg_o(tg_o), .ph1_o(ph1_o), .ph2_o(ph2_o), .ph1_last_o(ph1_last_o), .rs_o(rs_o),
    .cp_o(cp_o), .stb_o(pix_stb_o), .region_o(region_o), .busy_o(busy_o), .done_o(done_o)
  );
endmodule

// File: tb/ccd_line_timing_tb.sv
module ccd_line_timing_tb;
  localparam int SLOTS = 3719;
  localparam int PCYC  = 4;

  typedef struct packed {
    logic        mode;
    logic [15:0] tgw;
    logic [15:0] grd;
    logic [7:0]  rsw;
    logic [7:0]  clw;
    logic [31:0] exp_busy;
    logic [15:0] exp_tg;
  } vec_t;

  localparam vec_t VECS [3] = '{
    '{1'b0, 16'd150, 16'd50, 8'd1, 8'd2, 32'd15126, 16'd150},
    '{1'b1, 16'd200, 16'd60, 8'd2, 8'd1, 32'd15196, 16'd200},
    '{1'b0, 16'd0,   16'd0,  8'd2, 8'd2, 32'd14879, 16'd1}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, line_clamp_i = 1'b0;
  logic [15:0] tg_width_i = '0, guard_i = '0;
  logic [7:0]  rs_width_i = '0, clamp_width_i = '0;
  logic tg_o, ph1_o, ph2_o, ph1_last_o, rs_o, cp_o, pix_stb_o, busy_o, done_o;
  logic [1:0] region_o;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  ccd_line_timing u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .line_clamp_i(line_clamp_i),
    .tg_width_i(tg_width_i), .guard_i(guard_i), .rs_width_i(rs_width_i),
    .clamp_width_i(clamp_width_i), .tg_o(tg_o), .ph1_o(ph1_o), .ph2_o(ph2_o),
    .ph1_last_o(ph1_last_o), .rs_o(rs_o), .cp_o(cp_o), .pix_stb_o(pix_stb_o),
    .region_o(region_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic int exp_region(input int idx);
    if (idx < 15) return 0;
    if (idx < 63) return 1;
    if (idx < 66) return 2;
    if (idx < 3716) return 3;
    return 2;
  endfunction

  task automatic run_line(input vec_t v, input int trig_at, input logic [7:0] rsw_alt);
    int busy_cnt = 0, tg_cnt = 0, pre_cnt = 0, post_cnt = 0, quiet_err = 0;
    int stb_idx = 0, fall_cnt = 0, align_err = 0, compl_err = 0, reg_err = 0;
    int shift_cnt = 0, rs_sh = 0, cp_sh = 0, rs_tg = 0, rs_pre = 0, cp_line_err = 0;
    int done_cnt = 0, done_err = 0, geff, weff, exp_rs_tg = 0;
    bit seen_busy = 0, seen_tg = 0, seen_stb = 0, prev_done = 0, prev_ph1;
    geff = (v.grd == 0) ? 1 : int'(v.grd);
    weff = (v.tgw == 0) ? 1 : int'(v.tgw);
    for (int k = 0; k < weff; k++) if ((k % PCYC) < int'(v.rsw)) exp_rs_tg++;
    @(negedge clk);
    line_clamp_i = v.mode; tg_width_i = v.tgw; guard_i = v.grd;
    rs_width_i = v.rsw; clamp_width_i = v.clw; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    prev_ph1 = ph1_o;
    for (int cyc = 0; cyc < 20000; cyc++) begin
      @(negedge clk);
      if (seen_busy && !busy_o) break;
      if (busy_o) begin busy_cnt++; seen_busy = 1; end
      if (busy_o && !seen_tg && !tg_o) pre_cnt++;
      if (tg_o) begin
        tg_cnt++; seen_tg = 1; rs_tg += rs_o;
        if (!ph1_o || ph1_o != prev_ph1) quiet_err++;
      end
      if (seen_tg && !tg_o && !seen_stb && !pix_stb_o && busy_o) post_cnt++;
      if (prev_ph1 && !ph1_o) fall_cnt++;
      if (pix_stb_o) begin
        seen_stb = 1;
        if (int'(region_o) != exp_region(stb_idx)) reg_err++;
        if (!(prev_ph1 && !ph1_o)) align_err++;
        stb_idx++;
      end
      if (busy_o && !seen_stb) rs_pre += rs_o;
      if (busy_o && seen_stb) begin shift_cnt++; rs_sh += rs_o; cp_sh += cp_o; end
      if (v.mode && cp_o != !tg_o) cp_line_err++;
      if (ph2_o != !ph1_o || ph1_last_o != ph1_o) compl_err++;
      if (done_o) begin done_cnt++; if (!busy_o) done_err++; end
      if (prev_done && busy_o) done_err++;
      prev_done = done_o;
      prev_ph1 = ph1_o;
      start_i = (trig_at > 0 && busy_cnt == trig_at);
      if (start_i) rs_width_i = rsw_alt;
    end
    start_i = 1'b0;
    if (prev_done && busy_o) done_err++;
    check("R7 busy length", busy_cnt, v.exp_busy);
    check("R3 gate width", tg_cnt, v.exp_tg);
    check("R4 guard before gate", pre_cnt, geff);
    check("R4 guard after gate", post_cnt, geff);
    check("R4 phases parked in gate", quiet_err, 0);
    check("R1 strobe count", stb_idx, SLOTS);
    check("R1 ph1 falls", fall_cnt, SLOTS);
    check("R1 strobe on ph1 fall", align_err, 0);
    check("R1 phase relations", compl_err, 0);
    check("R1 shifting clocks", shift_cnt, SLOTS * PCYC);
    check("R2 region order", reg_err, 0);
    check("R7 one done", done_cnt, 1);
    check("R7 done on last busy", done_err, 0);
    check("R6 rs pulses in shift", rs_sh, SLOTS * int'(v.rsw));
    if (!v.mode) begin
      check("R5 clamp duty", cp_sh, SLOTS * int'(v.clw));
      check("R5 reset pulses in gate", rs_tg, exp_rs_tg);
    end else begin
      check("R6 reset held", rs_pre, 2 * geff + weff);
      check("R6 clamp is gate inverse", cp_line_err, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 tg", tg_o, 0);
    check("R9 ph1", ph1_o, 1);
    check("R9 ph2", ph2_o, 0);
    check("R9 ph1 last", ph1_last_o, 1);
    check("R9 rs", rs_o, 0);
    check("R9 cp", cp_o, 0);
    check("R9 strobe/region", {pix_stb_o, region_o}, 0);
    check("R9 busy/done", {busy_o, done_o}, 0);
    @(negedge clk); rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    for (int i = 0; i < 3; i++) run_line(VECS[i], 0, 8'd0);
    // R8: mid-line trigger and width change are ignored
    run_line('{1'b0, 16'd40, 16'd8, 8'd1, 8'd1, 32'd14932, 16'd40}, 5000, 8'd3);
    begin
      int late_busy = 0;
      for (int c = 0; c < 30; c++) begin
        @(negedge clk);
        late_busy += busy_o;
      end
      check("R8 no queued line", late_busy, 0);
    end
    summary();
  end
endmodule